// File: doc/BRIEF.md
# External Bus Cycle Sequencer for an 8-bit CPU

This block turns one transfer request from a CPU core into the clock-by-clock pattern of active-low strobes on an 8-bit processor's external bus. It handles five kinds of machine cycle. An opcode fetch is followed by a memory refresh slot. The other four are memory read, memory write, port read and port write. Each clock period is one T-state.

The core hands over one request at a time through a valid/ready pair. `req_ready` is high only while the sequencer is idle and no bus request is pending. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The core must hold the kind, address and write data stable until that edge. Read results come back on `rsp_valid`/`rsp_data` as a single-cycle pulse. The response path has no back-pressure, so the core must take the data in that cycle.

The block also handles bus release. An external master can take over the bus by pulling `busrq_n` low. The sequencer then stops driving every bus output and reports the release on `busak_n`. The block keeps a 7-bit refresh counter, and the core supplies the refresh address bit 7 and the interrupt page byte.

Top module: `bus_cycle_seq`

## Requirements
- R1: Opcode fetch (`req_kind`=0): `m1_n`, `mreq_n` and `rd_n` are low in T1, T2 and every Tw, and `addr_out` carries the request address.
- R2: Fetch T3 and T4 form the refresh slot. `rfsh_n` is low in both, `mreq_n` is low in T3 only, and `rd_n` and `m1_n` stay high. `addr_out[6:0]` is the refresh counter, `addr_out[7]` is `rfsh_msb`, and `addr_out[15:8]` is `int_page`.
- R3: The 7-bit refresh counter resets to 0 and steps by one after each fetch's T4. It wraps from 127 to 0, and bit 7 of the refresh address follows only `rfsh_msb`.
- R4: For fetch, memory read and memory write, `wait_n` is sampled at the end of T2 and at the end of each Tw. Every low sample adds one Tw, and the strobes are held unchanged during it.
- R5: Memory read (`req_kind`=1, and the unused codes 5 to 7) holds `mreq_n` and `rd_n` low from T1 to T3. `data_in` is captured at the end of T3. For a fetch it is captured at the end of the last of T2 or Tw. `rsp_valid` is high for the one cycle after the capture.
- R6: Memory write (`req_kind`=2) drives `data_oe` and `data_out` from T1 to T3. `mreq_n` and `wr_n` fall together in T2 and stay low through T3.
- R7: Port read (`req_kind`=3) and port write (`req_kind`=4) use `iorq_n` in place of `mreq_n`, with `rd_n` or `wr_n` from T2 to T3. `addr_out[7:0]` carries the port number. One automatic Tw always follows T2, and `wait_n` is first sampled at the end of that automatic Tw.
- R8: `busrq_n` is sampled at the end of each cycle's last T-state and on every idle cycle, and never in between. When it is sampled low, `busak_n` goes low, `addr_oe`, `ctrl_oe` and `data_oe` go low, and all strobes are high.
- R9: The release lasts until `busrq_n` is sampled high. In the next cycle `busak_n` is high, the outputs are driven again and `req_ready` returns.
- R10: `req_ready` is high only while idle with `busrq_n` high. Each accepted request produces exactly one machine cycle, and its T1 starts in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per T-state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core offers a transfer |
| req_ready | output | 1 | Sequencer can accept a transfer |
| req_kind | input | 3 | 0 fetch, 1 mem read, 2 mem write, 3 port read, 4 port write |
| req_addr | input | 16 | Memory address or port number |
| req_wdata | input | 8 | Write data |
| rfsh_msb | input | 1 | Bit 7 of the refresh address |
| int_page | input | 8 | Upper byte shown during refresh |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 8 | Captured read data |
| addr_out | output | 16 | Address bus value |
| addr_oe | output | 1 | Address bus drive enable |
| data_in | input | 8 | Data bus input |
| data_out | output | 8 | Data bus output value |
| data_oe | output | 1 | Data bus drive enable |
| ctrl_oe | output | 1 | Strobe drive enable |
| m1_n | output | 1 | Opcode fetch strobe |
| mreq_n | output | 1 | Memory request strobe |
| iorq_n | output | 1 | Port request strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| rfsh_n | output | 1 | Refresh strobe |
| wait_n | input | 1 | Slow device stretch request |
| busrq_n | input | 1 | External bus request |
| busak_n | output | 1 | Bus released acknowledge |

## Verification
Every cycle kind is run with zero to three low `wait_n` samples against three address and data patterns: all zeros, all ones and a mixed value. This separates the T-state counts of memory and port cycles, and it separates per-bit address and data faults. A long run of back-to-back fetches takes the refresh counter through its 127-to-0 wrap with both values of `rfsh_msb`. Bus requests are raised while the sequencer is idle and in the middle of a read, which shows that the strobe pattern is untouched until the cycle ends and that release happens only then.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IRD   = 3'd3,
    K_IWR   = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_T1, S_T2, S_TWA, S_TW, S_T3, S_T4, S_HOLD
  } tstate_e;

  function automatic kind_e decode_kind(input logic [2:0] code);
    case (code)
      3'd0: decode_kind = K_FETCH;
      3'd2: decode_kind = K_MWR;
      3'd3: decode_kind = K_IRD;
      3'd4: decode_kind = K_IWR;
      default: decode_kind = K_MRD;
    endcase
  endfunction
endpackage

// File: rtl/bcs_rfsh_ctr.sv
module bcs_rfsh_ctr #(
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [RW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> cnt == $past(cnt) + 1'b1);
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt));
endmodule

// File: rtl/bcs_tstate_fsm.sv
module bcs_tstate_fsm
  import bcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          wait_n,
  input  logic          busrq_n,
  output logic          req_ready,
  output tstate_e       st,
  output kind_e         kind,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          latch_en,
  output logic          rfsh_inc
);
  tstate_e nxt;
  logic    is_io, is_fetch, is_wr, last_t;

  assign is_fetch  = (kind == K_FETCH);
  assign is_io     = (kind == K_IRD) || (kind == K_IWR);
  assign is_wr     = (kind == K_MWR) || (kind == K_IWR);
  assign last_t    = (st == S_T4) || (st == S_T3 && !is_fetch);
  assign req_ready = (st == S_IDLE) && busrq_n;

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE:  if (!busrq_n) nxt = S_HOLD;
               else if (req_valid) nxt = S_T1;
      S_T1:    nxt = S_T2;
      S_T2:    if (is_io) nxt = S_TWA;
               else nxt = wait_n ? S_T3 : S_TW;
      S_TWA,
      S_TW:    nxt = wait_n ? S_T3 : S_TW;
      S_T3:    if (is_fetch) nxt = S_T4;
               else nxt = busrq_n ? S_IDLE : S_HOLD;
      S_T4:    nxt = busrq_n ? S_IDLE : S_HOLD;
      S_HOLD:  if (busrq_n) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind    <= K_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st <= nxt;
      if (req_valid && req_ready) begin
        kind    <= decode_kind(req_kind);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  assign latch_en = (is_fetch && (st == S_T2 || st == S_TW) && nxt == S_T3)
                 || (!is_fetch && !is_wr && st == S_T3);
  assign rfsh_inc = is_fetch && (st == S_T4);

  // R7
  io_auto_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T2 && is_io) |=> st == S_TWA);
  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_TW || st == S_TWA) && !wait_n) |=> st == S_TW);
  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> st == S_T1);
  // R9
  hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && busrq_n) |=> st == S_IDLE);
  // R8
  end_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_HOLD && !last_t && st != S_IDLE) |=> st != S_HOLD);
endmodule

// File: rtl/bcs_strobe_gen.sv
module bcs_strobe_gen
  import bcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int RW = 7,
  localparam int PGW = AW - RW - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  tstate_e        st,
  input  kind_e          kind,
  input  logic [AW-1:0]  addr_q,
  input  logic [DW-1:0]  wdata_q,
  input  logic [RW-1:0]  rcnt,
  input  logic           rmsb,
  input  logic [PGW-1:0] page,
  output logic [AW-1:0]  addr_out,
  output logic           addr_oe,
  output logic [DW-1:0]  data_out,
  output logic           data_oe,
  output logic           ctrl_oe,
  output logic           m1_n,
  output logic           mreq_n,
  output logic           iorq_n,
  output logic           rd_n,
  output logic           wr_n,
  output logic           rfsh_n,
  output logic           busak_n
);
  logic fetch, mrd, mwr, ird, iwr;
  logic pre, act, t3, rf_slot, hold;

  assign fetch = (kind == K_FETCH);
  assign mrd   = (kind == K_MRD);
  assign mwr   = (kind == K_MWR);
  assign ird   = (kind == K_IRD);
  assign iwr   = (kind == K_IWR);

  assign pre     = (st == S_T1) || (st == S_T2) || (st == S_TW);
  assign act     = (st == S_T2) || (st == S_TWA) || (st == S_TW) || (st == S_T3);
  assign t3      = (st == S_T3);
  assign rf_slot = fetch && (t3 || st == S_T4);
  assign hold    = (st == S_HOLD);

  assign m1_n   = !(fetch && pre);
  assign mreq_n = !((fetch && (pre || t3)) || (mrd && (pre || t3)) || (mwr && act));
  assign iorq_n = !((ird || iwr) && act);
  assign rd_n   = !((fetch && pre) || (mrd && (pre || t3)) || (ird && act));
  assign wr_n   = !((mwr || iwr) && act);
  assign rfsh_n = !rf_slot;

  assign addr_out = rf_slot ? {page, rmsb, rcnt} : addr_q;
  assign data_out = wdata_q;
  assign data_oe  = (mwr || iwr) && (st == S_T1 || act);
  assign addr_oe  = !hold;
  assign ctrl_oe  = !hold;
  assign busak_n  = !hold;

  // R2
  rfsh_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> (rd_n && m1_n));
  // R6
  wr_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (data_oe && (!mreq_n || !iorq_n)));
  // R7
  one_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mreq_n && !iorq_n));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int RW = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_kind,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic             rfsh_msb,
  input  logic [AW-RW-2:0] int_page,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic [AW-1:0]    addr_out,
  output logic             addr_oe,
  input  logic [DW-1:0]    data_in,
  output logic [DW-1:0]    data_out,
  output logic             data_oe,
  output logic             ctrl_oe,
  output logic             m1_n,
  output logic             mreq_n,
  output logic             iorq_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic             rfsh_n,
  input  logic             wait_n,
  input  logic             busrq_n,
  output logic             busak_n
);
  tstate_e       st;
  kind_e         kind;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          latch_en, rfsh_inc;
  logic [RW-1:0] rcnt;

  bcs_tstate_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .wait_n(wait_n),
    .busrq_n(busrq_n), .req_ready(req_ready), .st(st), .kind(kind),
    .addr_q(addr_q), .wdata_q(wdata_q), .latch_en(latch_en),
    .rfsh_inc(rfsh_inc)
  );

  bcs_rfsh_ctr #(.RW(RW)) u_rctr (
    .clk(clk), .rst_n(rst_n), .inc(rfsh_inc), .cnt(rcnt)
  );

  bcs_strobe_gen #(.AW(AW), .DW(DW), .RW(RW)) u_strb (
    .clk(clk), .rst_n(rst_n), .st(st), .kind(kind), .addr_q(addr_q),
    .wdata_q(wdata_q), .rcnt(rcnt), .rmsb(rfsh_msb), .page(int_page),
    .addr_out(addr_out), .addr_oe(addr_oe), .data_out(data_out),
    .data_oe(data_oe), .ctrl_oe(ctrl_oe), .m1_n(m1_n), .mreq_n(mreq_n),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .rfsh_n(rfsh_n),
    .busak_n(busak_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= latch_en;
      if (latch_en) rsp_data <= data_in;
    end
  end

  // R8
  hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busak_n |-> (!addr_oe && !ctrl_oe && !data_oe && !req_ready));
  // R5
  rsp_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!rd_n));
endmodule

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;
  localparam int PER = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic rfsh_msb = 1'b0;
  logic [7:0] int_page = 8'h3C;
  logic [7:0] data_in = '0;
  logic wait_n = 1'b1;
  logic busrq_n = 1'b1;
  logic req_ready, rsp_valid, addr_oe, data_oe, ctrl_oe;
  logic m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n, busak_n;
  logic [7:0] rsp_data, data_out;
  logic [15:0] addr_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [6:0] rexp = '0;

  always #(PER/2) clk = ~clk;

  bus_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .rfsh_msb(rfsh_msb), .int_page(int_page), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .addr_out(addr_out), .addr_oe(addr_oe),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .ctrl_oe(ctrl_oe), .m1_n(m1_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .rfsh_n(rfsh_n), .wait_n(wait_n),
    .busrq_n(busrq_n), .busak_n(busak_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // labels: 1 T1, 2 T2, 3 auto Tw, 4 Tw, 5 T3, 6 T4
  // bits {m1, mreq, iorq, rd, wr, rfsh}, active high
  function automatic logic [5:0] exp_ctl(input int k, input int l);
    case (k)
      0: exp_ctl = (l <= 4) ? 6'b110100 : (l == 5) ? 6'b010001 : 6'b000001;
      2: exp_ctl = (l == 1) ? 6'b000000 : 6'b010010;
      3: exp_ctl = (l == 1) ? 6'b000000 : 6'b001100;
      4: exp_ctl = (l == 1) ? 6'b000000 : 6'b001010;
      default: exp_ctl = 6'b010100;
    endcase
  endfunction

  function automatic string tag_of(input int k, input int l);
    case (k)
      0: tag_of = (l >= 5) ? "R2" : "R1";
      2: tag_of = "R6";
      3, 4: tag_of = "R7";
      default: tag_of = "R5";
    endcase
  endfunction

  task automatic run_access(input int k, input logic [15:0] a,
                            input logic [7:0] wd, input int nw,
                            input bit mid_busrq);
    int lbl;
    int rem;
    bit done;
    bit io;
    bit wlow;
    logic [7:0] din;
    logic [5:0] act;
    io = (k == 3) || (k == 4);
    din = a[7:0] ^ 8'h5A ^ wd;
    @(negedge clk);
    // R10: ready while idle
    chk(req_ready === 1'b1, "R10 ready idle", {31'd0, req_ready}, 1);
    req_valid = 1'b1; req_kind = k[2:0]; req_addr = a; req_wdata = wd;
    data_in = din;
    @(posedge clk);
    #1 req_valid = 1'b0;
    lbl = 1; rem = nw; done = 1'b0;
    while (!done) begin
      @(negedge clk);
      if (mid_busrq && lbl == 1) busrq_n = 1'b0;
      wlow = ((lbl == 2 && !io) || lbl == 3 || lbl == 4) && rem > 0;
      wait_n = !wlow;
      #1;
      act = {~m1_n, ~mreq_n, ~iorq_n, ~rd_n, ~wr_n, ~rfsh_n};
      chk(act === exp_ctl(k, lbl) && busak_n && ctrl_oe && addr_oe,
          tag_of(k, lbl), {23'd0, busak_n, ctrl_oe, lbl[2:0], act},
          {23'd0, 2'b11, lbl[2:0], exp_ctl(k, lbl)});
      if (k == 0 && lbl >= 5)
        chk(addr_out === {int_page, rfsh_msb, rexp}, "R2/R3 refresh addr",
            {16'd0, addr_out}, {16'd0, int_page, rfsh_msb, rexp});
      else if (io)
        chk(addr_out[7:0] === a[7:0], "R7 port addr", {24'd0, addr_out[7:0]},
            {24'd0, a[7:0]});
      else
        chk(addr_out === a, tag_of(k, lbl), {16'd0, addr_out}, {16'd0, a});
      if (k == 2 || k == 4)
        chk(data_oe === 1'b1 && data_out === wd, "R6 write data",
            {23'd0, data_oe, data_out}, {23'd0, 1'b1, wd});
      else
        chk(data_oe === 1'b0, "R5 no drive on read", {31'd0, data_oe}, 0);
      if (k == 0 && lbl == 5)
        chk(rsp_valid === 1'b1 && rsp_data === din, "R5 fetch data",
            {23'd0, rsp_valid, rsp_data}, {23'd0, 1'b1, din});
      case (lbl)
        1: lbl = 2;
        2: lbl = io ? 3 : (wlow ? 4 : 5);
        3, 4: lbl = wlow ? 4 : 5;
        5: if (k == 0) lbl = 6; else done = 1'b1;
        default: done = 1'b1;
      endcase
      if (wlow) rem--;
    end
    @(negedge clk);
    wait_n = 1'b1;
    #1;
    if (k == 1 || k == 3 || k >= 5)
      chk(rsp_valid === 1'b1 && rsp_data === din, "R5 read data",
          {23'd0, rsp_valid, rsp_data}, {23'd0, 1'b1, din});
    else
      chk(rsp_valid === 1'b0, "R5 no response", {31'd0, rsp_valid}, 0);
    if (mid_busrq)
      chk(busak_n === 1'b0 && req_ready === 1'b0 && addr_oe === 1'b0,
          "R8 release after cycle", {29'd0, busak_n, req_ready, addr_oe}, 0);
    else
      // R4: cycle length matches the number of low wait samples
      chk(req_ready === 1'b1 && busak_n === 1'b1, "R4 cycle length",
          {30'd0, req_ready, busak_n}, 3);
    if (k == 0) rexp = rexp + 1'b1;
  endtask

  initial begin
    #(PER * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [15:0] pats [3];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk({m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n, busak_n} === 7'h7F &&
        req_ready === 1'b1 && rsp_valid === 1'b0, "R10 reset state",
        {23'd0, m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n, busak_n,
         req_ready, rsp_valid}, {23'd0, 9'b111111110});

    for (int k = 0; k < 6; k++)
      for (int nw = 0; nw < 4; nw++)
        for (int p = 0; p < 3; p++) begin
          int_page = pats[p][15:8];
          rfsh_msb = p[0];
          run_access(k, pats[p] ^ {nw[7:0], k[7:0]}, ~pats[p][7:0], nw, 1'b0);
        end

    // R3: run the refresh counter across its wrap
    for (int i = 0; i < 140; i++) begin
      rfsh_msb = i[3];
      int_page = i[7:0];
      run_access(0, 16'h1000 + i[15:0], 8'h00, 0, 1'b0);
    end

    // R8: request while idle
    @(negedge clk) busrq_n = 1'b0;
    req_valid = 1'b1; req_kind = 3'd1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1;
      chk(busak_n === 1'b0 && addr_oe === 1'b0 && ctrl_oe === 1'b0 &&
          data_oe === 1'b0 && req_ready === 1'b0 && mreq_n === 1'b1,
          "R8 idle release", {26'd0, busak_n, addr_oe, ctrl_oe, data_oe,
          req_ready, mreq_n}, 32'h1);
    end
    req_valid = 1'b0;
    busrq_n = 1'b1;
    @(negedge clk);
    #1;
    chk(busak_n === 1'b1 && req_ready === 1'b1 && ctrl_oe === 1'b1 &&
        addr_oe === 1'b1, "R9 resume", {28'd0, busak_n, req_ready, ctrl_oe,
        addr_oe}, 32'hF);

    // R8: request raised inside a read; cycle completes untouched
    for (int nw = 0; nw < 3; nw++) begin
      run_access(1, 16'h2468 + nw[15:0], 8'h00, nw, 1'b1);
      busrq_n = 1'b1;
      @(negedge clk);
      #1;
      chk(busak_n === 1'b1 && req_ready === 1'b1, "R9 resume after cycle",
          {30'd0, busak_n, req_ready}, 3);
    end
    run_access(3, 16'h00F7, 8'h00, 1, 1'b1);
    busrq_n = 1'b1;
    @(negedge clk);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule